// File: doc/BRIEF.md
# Oversampling Chopper Result Accumulator

This block sits behind a 10-bit successive-approximation converter. It sums a programmable group of raw conversions into one wide result. Each accepted sample arrives with a one-cycle valid strobe. A 3-bit count code sets the group size to a power of two, and the finished sum is written out left-justified in a 16-bit word. Each doubling of the group adds one bit of resolution below the original ten.

With chopper mode on, the block toggles a sign line to the converter on every accepted sample. Both the analog input and the digital output are inverted on every second sample. The block complements those samples back before adding them, so the converter's internal offset cancels over each pair. Chopper mode always takes at least two samples.

The block also tells the converter which offset-trim word applies to the sample in flight. This depends on single-ended or differential mode and on the present sign. A mute input replaces the sample with mid-scale, so the converter's own offset and noise can be measured through the same path.

Top module: `ovs_chop_accum`

## Requirements
- R1: After reset, result_o is 0, done_o is 0 and sign_o is 0.
- R2: With chopper off, a group holds 2^c samples, where c is the count code (c = 0 gives 1 sample, c = 7 gives 128). done_o is high for exactly the cycle after the clock edge that accepts the group's last sample.
- R3: With chopper on and c = 0, a group holds two samples. For c ≥ 1 it holds 2^c samples.
- R4: sign_o is 0 for the first sample of every group. With chopper on, it inverts after each accepted sample inside a group. With chopper off, it stays 0. It is 0 again after the last sample of a group.
- R5: A sample accepted while sign_o is 1 is added as 1023 − x. A sample accepted while sign_o is 0 is added as x.
- R6: With S the group sum and k = log2 of the group size, the result is (S · 64) >> k, kept to 16 bits. That is S shifted left by 6 − k when k ≤ 6, and S shifted right by one when k = 7.
- R7: trim_pos_o = (single_ended_i == 0) or (sign_o == 0), and trim_neg_o = (single_ended_i == 0) or (sign_o == 1). Both outputs are combinational on the present inputs and sign.
- R8: With mute_i high, the sample value is taken as 512 (so 511 after complementing), and smp_data_i is ignored.
- R9: result_o changes only together with a done_o pulse and holds its value in between.
- R10: The count code and the chopper enable are captured with a group's first sample. Changing them later in the group has no effect until the next group.
- R11: Cycles with smp_valid_i low change neither sign_o, the running sum nor the group position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | A conversion result is present this cycle |
| smp_data_i | input | 10 | Raw conversion result |
| cnt_code_i | input | 3 | Group size code c, 2^c samples |
| chop_en_i | input | 1 | Chopper mode enable |
| single_ended_i | input | 1 | 1 = single-ended input, 0 = differential |
| mute_i | input | 1 | Replace the sample with mid-scale |
| sign_o | output | 1 | Input/output inversion control to the converter |
| trim_pos_o | output | 1 | Positive-array offset trim applies |
| trim_neg_o | output | 1 | Negative-array offset trim applies |
| result_o | output | 16 | Left-justified accumulated result |
| done_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
The bench sweeps every count code with chopper both off and on. A design that missed the forced pair at c = 0 would fire done after one sample, and a wrong shift would misplace the result by a power of two. At 128 samples, a full-scale sum overflows 16 bits unless the format drops the low bit rather than the high one; the bench feeds near-full-scale data there. Mute mixed with an inverted sample must give 511, not 512. Code and chopper changes in mid-group, and gaps in the valid strobe, would move the done pulse or corrupt the sign sequence in a design that read them live.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  parameter int SMP_W  = 10;
  parameter int CODE_W = 3;
  parameter int RES_W  = 16;
endpackage

// File: rtl/ovs_ctrl.sv
module ovs_ctrl #(
  parameter int CODE_W = 3,
  parameter int IDX_W  = (1 << CODE_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              chop_i,
  output logic              sign_o,
  output logic              last_o,
  output logic [CODE_W-1:0] shift_o
);
  logic [IDX_W-1:0]  cnt_q;
  logic [CODE_W-1:0] code_q, eff_code;
  logic              chop_q, eff_chop, sign_q, first;
  logic [IDX_W:0]    grp_n;

  assign first    = (cnt_q == '0);
  assign eff_code = first ? code_i : code_q;
  assign eff_chop = first ? chop_i : chop_q;
  // chopper needs a pair even at code 0
  assign shift_o  = (eff_code == '0 && eff_chop) ? CODE_W'(1) : eff_code;
  assign grp_n    = (IDX_W+1)'(1) << shift_o;
  assign last_o   = (({1'b0, cnt_q} + (IDX_W+1)'(1)) == grp_n);
  assign sign_o   = sign_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      code_q <= '0;
      chop_q <= 1'b0;
      sign_q <= 1'b0;
    end else if (valid_i) begin
      if (first) begin
        code_q <= code_i;
        chop_q <= chop_i;
      end
      if (last_o) begin
        cnt_q  <= '0;
        sign_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_q + IDX_W'(1);
        sign_q <= eff_chop & ~sign_q;
      end
    end
  end
endmodule

// File: rtl/ovs_accum.sv
module ovs_accum #(
  parameter int SMP_W = 10,
  parameter int SUM_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             last_i,
  input  logic             sign_i,
  input  logic             mute_i,
  input  logic [SMP_W-1:0] data_i,
  output logic [SUM_W-1:0] sum_o
);
  localparam logic [SMP_W-1:0] MID  = SMP_W'(1) << (SMP_W - 1);
  localparam logic [SMP_W-1:0] FULL = '1;

  logic [SUM_W-1:0] acc_q;
  logic [SMP_W-1:0] raw, cond;

  assign raw   = mute_i ? MID : data_i;
  assign cond  = sign_i ? FULL - raw : raw;
  assign sum_o = acc_q + SUM_W'(cond);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (valid_i) acc_q <= last_i ? '0 : sum_o;
  end
endmodule

// File: rtl/ovs_result.sv
module ovs_result #(
  parameter int SUM_W  = 17,
  parameter int RES_W  = 16,
  parameter int EXTRA  = 6,
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [CODE_W-1:0] shift_i,
  input  logic [SUM_W-1:0]  sum_i,
  output logic [RES_W-1:0]  result_o,
  output logic              done_o
);
  logic [SUM_W+EXTRA-1:0] wide;

  // left-justify: scale by 2^EXTRA, divide by group size
  assign wide = {sum_i, {EXTRA{1'b0}}} >> shift_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= fire_i;
      if (fire_i) result_o <= wide[RES_W-1:0];
    end
  end
endmodule

// File: rtl/ovs_chop_accum.sv
module ovs_chop_accum
  import ovs_pkg::*;
#(
  parameter int SW = SMP_W,
  parameter int CW = CODE_W,
  parameter int RW = RES_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  input  logic [SW-1:0] smp_data_i,
  input  logic [CW-1:0] cnt_code_i,
  input  logic          chop_en_i,
  input  logic          single_ended_i,
  input  logic          mute_i,
  output logic          sign_o,
  output logic          trim_pos_o,
  output logic          trim_neg_o,
  output logic [RW-1:0] result_o,
  output logic          done_o
);
  localparam int IDX_W = (1 << CW) - 1;
  localparam int SUM_W = SW + IDX_W;
  localparam int EXTRA = RW - SW;

  logic          last;
  logic [CW-1:0] shift;
  logic [SUM_W-1:0] sum;

  ovs_ctrl #(.CODE_W(CW), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni,
    .valid_i (smp_valid_i),
    .code_i  (cnt_code_i),
    .chop_i  (chop_en_i),
    .sign_o  (sign_o),
    .last_o  (last),
    .shift_o (shift)
  );

  ovs_accum #(.SMP_W(SW), .SUM_W(SUM_W)) u_accum (
    .clk_i, .rst_ni,
    .valid_i (smp_valid_i),
    .last_i  (last),
    .sign_i  (sign_o),
    .mute_i  (mute_i),
    .data_i  (smp_data_i),
    .sum_o   (sum)
  );

  ovs_result #(.SUM_W(SUM_W), .RES_W(RW), .EXTRA(EXTRA), .CODE_W(CW)) u_result (
    .clk_i, .rst_ni,
    .fire_i   (smp_valid_i & last),
    .shift_i  (shift),
    .sum_i    (sum),
    .result_o (result_o),
    .done_o   (done_o)
  );

  assign trim_pos_o = ~single_ended_i | ~sign_o;
  assign trim_neg_o = ~single_ended_i |  sign_o;
endmodule

// File: rtl/ovs_chop_accum_chk.sv
module ovs_chop_accum_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        smp_valid_i,
  input logic        single_ended_i,
  input logic        sign_o,
  input logic        trim_pos_o,
  input logic        trim_neg_o,
  input logic [15:0] result_o,
  input logic        done_o
);
  assert_result_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> ($stable(sign_o) && !done_o));
  assert_done_after_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(smp_valid_i));
  assert_sign_clear_at_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !sign_o);
  assert_trim_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_ended_i |-> (trim_pos_o != trim_neg_o));
  assert_trim_both_diff_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !single_ended_i |-> (trim_pos_o && trim_neg_o));
endmodule

bind ovs_chop_accum ovs_chop_accum_chk u_chk (
  .clk_i, .rst_ni, .smp_valid_i, .single_ended_i,
  .sign_o, .trim_pos_o, .trim_neg_o, .result_o, .done_o
);

// File: tb/ovs_chop_accum_test.sv
module ovs_chop_accum_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, chop = 1'b0, se = 1'b0, mute = 1'b0;
  logic [9:0] data = '0;
  logic [2:0] code = '0;
  logic sign, tpos, tneg, done;
  logic [15:0] result;

  int n_vec = 0, n_bad = 0;
  string tag = "R1";
  // reference model state
  int m_cnt = 0, m_n = 1, m_sum = 0, m_res = 0;
  bit m_sign = 0, m_chop = 0, m_done = 0;

  always #5 clk = ~clk;

  ovs_chop_accum uut (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid), .smp_data_i(data),
    .cnt_code_i(code), .chop_en_i(chop), .single_ended_i(se), .mute_i(mute),
    .sign_o(sign), .trim_pos_o(tpos), .trim_neg_o(tneg),
    .result_o(result), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    n_vec++;
    chk({tag, "/R4 sign"}, int'(sign), int'(m_sign));
    chk({tag, "/R7 trim_pos"}, int'(tpos), int'(!se || !m_sign));
    chk({tag, "/R7 trim_neg"}, int'(tneg), int'(!se || m_sign));
    chk({tag, "/R2 done"}, int'(done), int'(m_done));
    chk({tag, "/R6 result"}, int'(result), m_res);
  endtask

  task automatic model_step();
    int x, k;
    m_done = 0;
    if (!valid) return;
    if (m_cnt == 0) begin
      m_n    = (code == 0 && chop) ? 2 : (1 << code);
      m_chop = chop;
    end
    x = mute ? 512 : int'(data);
    if (m_sign) x = 1023 - x;
    m_sum += x;
    m_cnt++;
    if (m_cnt == m_n) begin
      k = $clog2(m_n);
      m_res  = (m_sum * 64 >> k) & 16'hffff;
      m_done = 1;
      m_sum = 0; m_cnt = 0; m_sign = 0;
    end else m_sign = m_chop ? !m_sign : 1'b0;
  endtask

  // one cycle: drive at negedge, model after posedge, compare at next negedge
  task automatic cyc(input bit v, input int d, input int c, input bit ch,
                     input bit s, input bit mu);
    valid = v; data = 10'(d); code = 3'(c); chop = ch; se = s; mute = mu;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic group(input int c, input bit ch, input int hi, input bit gaps);
    int n = (c == 0 && ch) ? 2 : (1 << c);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) cyc(0, 77, 7 - c, !ch, i[0], 1);
      cyc(1, int'($urandom_range(hi, hi > 100 ? hi - 100 : 0)), c, ch, i[1], 0);
    end
    cyc(0, 0, c, ch, 1, 0);
  endtask

  initial begin
    void'($urandom(13));
    @(negedge clk);
    compare();                      // R1 under reset
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1"; compare();

    tag = "R2";                     // no chopper, every code
    for (int c = 0; c < 8; c++) group(c, 0, 1023, 0);
    tag = "R3";                     // chopper, every code, incl. forced pair
    for (int c = 0; c < 8; c++) group(c, 1, 900, 0);
    tag = "R5";                     // full scale, inverted samples, 128 samples
    group(7, 1, 1023, 0);
    group(7, 0, 1023, 0);
    group(6, 0, 1023, 0);
    tag = "R11";                    // gaps with noise on the other inputs
    group(3, 1, 500, 1);
    group(5, 0, 600, 1);
    tag = "R8";                     // mute in and out of chopper
    for (int i = 0; i < 4; i++) cyc(1, 5, 2, 1, 1, 1);
    for (int i = 0; i < 2; i++) cyc(1, 1000, 1, 0, 0, 1);
    cyc(1, 3, 0, 1, 1, 1); cyc(1, 9, 0, 1, 1, 0);
    tag = "R10";                    // code/chop change mid-group
    cyc(1, 100, 2, 1, 1, 0);
    cyc(1, 200, 7, 0, 1, 0);
    cyc(1, 300, 0, 0, 0, 0);
    cyc(1, 400, 5, 1, 1, 0);
    cyc(1, 50, 0, 0, 1, 0);         // next group uses new code 0
    tag = "R9";                     // hold between groups
    for (int i = 0; i < 6; i++) cyc(0, 999, 4, 1, i[0], 0);
    group(4, 1, 300, 0);
    for (int i = 0; i < 40; i++) cyc(1, 100 + i, 1, i[2], 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule